// File: doc/BRIEF.md
# I2C Master Enable Handshake

This block owns the enable control of an I2C master. It holds the enable request that software writes, and a separate enable status that shows the state the engine has really reached. Turning the master on takes effect at once. Turning it off is handled in two steps when a transfer is running. The block first asks the engine to finish the current byte and issue STOP. Once the engine reports the bus idle, the status drops and a one-cycle flush pulse empties the transmit and receive queues and clears the raw interrupt flags. Software writes the request and then polls the status until the two agree. Turning the master off and on again is the usual soft reset after a timeout or a bus error.

The block also holds the configuration registers: the control word, the SCL high and low counts, and the threshold. It also holds the target address register. All of these accept writes only while the status shows the master disabled. The ten-bit addressing flag in the control word can be cleared only while the target address register holds zero. Software therefore zeroes the address before it rewrites the control word and enables the master.

Top module: `i2cm_enable_hs`

## Requirements
- R1: After reset the request, the status, stop_req_o and flush_o are all 0, and every configuration register and the target address register read 0.
- R2: A write of 1 to the enable request while the block is disabled sets core_en_o at that same clock edge. No flush pulse follows.
- R3: When the request is cleared while eng_busy is 1 or eng_idle is 0, core_en_o stays 1 and stop_req_o is 1. This lasts until the first clock edge at which eng_idle is 1 and eng_busy is 0.
- R4: Core_en_o falls at the edge where the drain completes. At that same edge flush_o rises, and it stays high for exactly one cycle.
- R5: A disable written while the engine is already idle (eng_idle 1, eng_busy 0) completes one clock edge after the write edge.
- R6: A write of 1 to the request during a pending disable cancels the disable. Core_en_o stays 1, stop_req_o drops, and no flush pulse occurs.
- R7: The request readback en_req_o always shows the last value written to the request bit.
- R8: A configuration write (cfg_sel selects register 0 to NCFG-1; register 0 is the control word) or a target address write updates the register only while core_en_o is 0. While core_en_o is 1 the register keeps its value.
- R9: Bit TENBIT_POS (default 4) of the control word can go from 1 to 0 only when the target address register is zero. If the address is nonzero, a write keeps that bit at 1 and takes every other bit from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Strobe that writes the enable request |
| en_bit | input | 1 | Value written to the request (1 enable, 0 disable) |
| eng_busy | input | 1 | The engine is in the middle of a transfer |
| eng_idle | input | 1 | The engine has issued STOP and the bus is idle |
| cfg_wr | input | 1 | Strobe that writes a configuration register |
| cfg_sel | input | SEL_W | Index of the configuration register to write |
| cfg_wdata | input | CFG_W | Configuration write data |
| tar_wr | input | 1 | Strobe that writes the target address |
| tar_wdata | input | ADDR_W | Target address write data |
| en_req_o | output | 1 | Readback of the enable request |
| core_en_o | output | 1 | Enable actually in force; also the status readback |
| stop_req_o | output | 1 | Asks the engine to finish the current byte and issue STOP |
| flush_o | output | 1 | One-cycle pulse that flushes the queues and clears the raw flags |
| cfg_q_o | output | NCFG*CFG_W | Configuration registers, register 0 in the low bits |
| tar_q_o | output | ADDR_W | Target address register |

## Verification
The assertions assume that the engine never reports busy and idle as true together once it has seen stop_req_o. They also assume that cfg_sel stays below NCFG. The bench drives busy and idle as a complementary pair, so the engine is either mid-transfer or idle and never both. It sweeps only the four existing register indices. Every write strobe lasts exactly one cycle and is applied on the falling edge, so each strobe meets exactly one rising edge.

// File: rtl/i2cm_en_pkg.sv
package i2cm_en_pkg;

  typedef enum logic [1:0] {
    EN_OFF   = 2'd0,
    EN_ON    = 2'd1,
    EN_DRAIN = 2'd2
  } en_state_e;

  // The drain may finish only once the engine has released the bus.
  function automatic logic drain_ok(input logic busy, input logic idle);
    return idle & ~busy;
  endfunction

endpackage

// File: rtl/i2cm_en_fsm.sv
module i2cm_en_fsm
  import i2cm_en_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_bit,
  input  logic eng_busy,
  input  logic eng_idle,
  output logic en_req,
  output logic core_en,
  output logic stop_req,
  output logic flush
);

  en_state_e state_q, state_d;
  logic      go_on, go_off, drain_done;

  assign go_on      = en_wr & en_bit;
  assign go_off     = en_wr & ~en_bit;
  assign drain_done = drain_ok(eng_busy, eng_idle);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      EN_OFF:   if (go_on) state_d = EN_ON;
      EN_ON:    if (go_off) state_d = EN_DRAIN;
      EN_DRAIN: begin
        if (go_on)           state_d = EN_ON;
        else if (drain_done) state_d = EN_OFF;
      end
      default:  state_d = EN_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EN_OFF;
      en_req  <= 1'b0;
      flush   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (en_wr) en_req <= en_bit;
      flush   <= (state_q == EN_DRAIN) && (state_d == EN_OFF);
    end
  end

  assign core_en  = (state_q != EN_OFF);
  assign stop_req = (state_q == EN_DRAIN);

  AST_ENABLE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && en_bit) |=> core_en); // R2
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && eng_busy) |=> core_en); // R3
  AST_FLUSH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_en) |-> flush); // R4
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush); // R4
  AST_REQ_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_req == $past(en_bit))); // R7

endmodule

// File: rtl/i2cm_cfg_bank.sv
module i2cm_cfg_bank #(
  parameter int NCFG       = 4,
  parameter int CFG_W      = 16,
  parameter int ADDR_W     = 10,
  parameter int TENBIT_POS = 4,
  localparam int SEL_W     = (NCFG > 1) ? $clog2(NCFG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  locked,
  input  logic                  cfg_wr,
  input  logic [SEL_W-1:0]      cfg_sel,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic                  tar_wr,
  input  logic [ADDR_W-1:0]     tar_wdata,
  output logic [NCFG*CFG_W-1:0] cfg_q,
  output logic [ADDR_W-1:0]     tar_q
);

  // The ten-bit flag may be lowered only while the address is zero.
  function automatic logic [CFG_W-1:0] ctl_merge(input logic [CFG_W-1:0] old_v,
                                                 input logic [CFG_W-1:0] new_v,
                                                 input logic             tar_zero);
    logic [CFG_W-1:0] r;
    r = new_v;
    if (!tar_zero && old_v[TENBIT_POS]) r[TENBIT_POS] = 1'b1;
    return r;
  endfunction

  logic tar_zero;
  logic open_wr;

  assign tar_zero = (tar_q == '0);
  assign open_wr  = ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tar_q <= '0;
    else if (tar_wr && open_wr) tar_q <= tar_wdata;
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_reg
    logic hit;
    assign hit = cfg_wr && open_wr && (cfg_sel == SEL_W'(g));
    if (g == 0) begin : g_ctl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cfg_q[CFG_W-1:0] <= '0;
        else if (hit) cfg_q[CFG_W-1:0] <= ctl_merge(cfg_q[CFG_W-1:0], cfg_wdata, tar_zero);
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cfg_q[g*CFG_W +: CFG_W] <= '0;
        else if (hit) cfg_q[g*CFG_W +: CFG_W] <= cfg_wdata;
      end
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_q)); // R8
  AST_TAR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(tar_q)); // R8
  AST_TENBIT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_q[TENBIT_POS]) |-> ($past(tar_q) == '0)); // R9

endmodule

// File: rtl/i2cm_enable_hs.sv
module i2cm_enable_hs #(
  parameter int NCFG       = 4,
  parameter int CFG_W      = 16,
  parameter int ADDR_W     = 10,
  parameter int TENBIT_POS = 4,
  localparam int SEL_W     = (NCFG > 1) ? $clog2(NCFG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_wr,
  input  logic                  en_bit,
  input  logic                  eng_busy,
  input  logic                  eng_idle,
  input  logic                  cfg_wr,
  input  logic [SEL_W-1:0]      cfg_sel,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic                  tar_wr,
  input  logic [ADDR_W-1:0]     tar_wdata,
  output logic                  en_req_o,
  output logic                  core_en_o,
  output logic                  stop_req_o,
  output logic                  flush_o,
  output logic [NCFG*CFG_W-1:0] cfg_q_o,
  output logic [ADDR_W-1:0]     tar_q_o
);

  logic core_en_w;

  i2cm_en_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (en_wr),
    .en_bit   (en_bit),
    .eng_busy (eng_busy),
    .eng_idle (eng_idle),
    .en_req   (en_req_o),
    .core_en  (core_en_w),
    .stop_req (stop_req_o),
    .flush    (flush_o)
  );

  i2cm_cfg_bank #(
    .NCFG       (NCFG),
    .CFG_W      (CFG_W),
    .ADDR_W     (ADDR_W),
    .TENBIT_POS (TENBIT_POS)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (core_en_w),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tar_wr    (tar_wr),
    .tar_wdata (tar_wdata),
    .cfg_q     (cfg_q_o),
    .tar_q     (tar_q_o)
  );

  assign core_en_o = core_en_w;

  AST_NO_STOP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req_o |-> core_en_o); // R3

endmodule

// File: tb/sim_i2cm_enable_hs.sv
module sim_i2cm_enable_hs;
  localparam int NCFG = 4, CFG_W = 16, ADDR_W = 10, TB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_wr = 0, en_bit = 0, eng_busy = 0, eng_idle = 1;
  logic cfg_wr = 0, tar_wr = 0;
  logic [1:0] cfg_sel = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [ADDR_W-1:0] tar_wdata = '0;
  logic en_req_o, core_en_o, stop_req_o, flush_o;
  logic [NCFG*CFG_W-1:0] cfg_q_o;
  logic [ADDR_W-1:0] tar_q_o;
  int checks = 0, errors = 0;
  logic [CFG_W-1:0] model [NCFG];

  always #2.5 clk = ~clk;

  i2cm_enable_hs u0 (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_en(input logic v);
    @(negedge clk); en_wr = 1; en_bit = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic wr_cfg(input int s, input int v);
    @(negedge clk); cfg_wr = 1; cfg_sel = 2'(s); cfg_wdata = CFG_W'(v);
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic wr_tar(input int v);
    @(negedge clk); tar_wr = 1; tar_wdata = ADDR_W'(v);
    @(negedge clk); tar_wr = 0;
  endtask

  task automatic set_busy(input logic b);
    @(negedge clk); eng_busy = b; eng_idle = ~b;
  endtask

  task automatic disable_idle();
    set_busy(0);
    wr_en(0);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!core_en_o && !en_req_o && !stop_req_o && !flush_o, "R1", core_en_o, 0);
    chk(cfg_q_o == '0 && tar_q_o == '0, "R1", int'(cfg_q_o[31:0]), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 immediate enable
    wr_en(1);
    chk(core_en_o == 1, "R2", core_en_o, 1);
    chk(en_req_o == 1, "R7", en_req_o, 1);
    chk(flush_o == 0, "R2", flush_o, 0);

    // R3 disable while busy: sweep hold lengths
    for (int n = 1; n <= 5; n++) begin
      set_busy(1);
      wr_en(0);
      chk(en_req_o == 0, "R7", en_req_o, 0);
      for (int k = 0; k < n; k++) begin
        chk(core_en_o == 1 && stop_req_o == 1, "R3", core_en_o, 1);
        @(negedge clk);
      end
      eng_busy = 0; eng_idle = 1;
      @(negedge clk);
      chk(core_en_o == 0 && flush_o == 1, "R4", {core_en_o, flush_o}, 1);
      @(negedge clk);
      chk(flush_o == 0 && stop_req_o == 0, "R4", flush_o, 0);
      wr_en(1);
    end

    // R5 disable while already idle
    set_busy(0);
    wr_en(0);
    chk(core_en_o == 1 && flush_o == 0, "R5", core_en_o, 1);
    @(negedge clk);
    chk(core_en_o == 0 && flush_o == 1, "R5", {core_en_o, flush_o}, 1);

    // R6 re-enable cancels pending disable
    wr_en(1);
    set_busy(1);
    wr_en(0);
    wr_en(1);
    chk(stop_req_o == 0 && core_en_o == 1, "R6", stop_req_o, 0);
    set_busy(0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(core_en_o == 1 && flush_o == 0, "R6", {core_en_o, flush_o}, 2);
    end

    // R8 writes blocked while enabled, accepted while disabled
    disable_idle();
    for (int s = 0; s < NCFG; s++) model[s] = '0;
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1) wr_en(1);
      for (int s = 0; s < NCFG; s++)
        for (int k = 0; k < 3; k++) begin
          int v;
          v = (s * 16'h1111 + k * 16'h0203 + ph * 16'h4000) & 16'hFFEF;
          wr_cfg(s, v);
          if (ph == 0) model[s] = CFG_W'(v);
          chk(cfg_q_o[s*CFG_W +: CFG_W] == model[s], "R8",
              int'(cfg_q_o[s*CFG_W +: CFG_W]), int'(model[s]));
        end
      wr_tar(16'h155 + ph);
      chk(tar_q_o == ADDR_W'(16'h155), "R8", int'(tar_q_o), 16'h155);
    end
    disable_idle();

    // R9 ten-bit flag clear guarded by the target address
    for (int t = 0; t < 6; t++) begin
      int tv, exp;
      tv = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 2 : (t == 3) ? 'h200 : (t == 4) ? 'h3FF : 0;
      wr_tar(0);
      wr_cfg(0, 'h0013);
      wr_tar(tv);
      wr_cfg(0, 'h0003);
      exp = (tv == 0) ? 'h0003 : 'h0013;
      chk(int'(cfg_q_o[CFG_W-1:0]) == exp, "R9", int'(cfg_q_o[CFG_W-1:0]), exp);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule